// File: doc/BRIEF.md
# Port Pin Function Assignment Register

This block is an 8-bit memory-mapped control register that decides, pin by pin, whether one 8-pin port of a microcontroller works as general-purpose I/O or carries an alternate bus-control function. The alternate functions are an auxiliary active-high reset input, a pipe-status pair, a PLL test output, an E-clock output, a low-byte strobe and a read/write strobe. When a pin's alternate function is enabled, the function takes over that pin's output enable and output data. The port's own direction and data registers then have no effect on the pin.

The 3-bit operating mode is captured while reset is held. It sets the reset image, the write rules of each bit and whether the register is visible on the bus at all. A small access state machine tracks what happens to the register after reset:

- **ACC_FRESH** means no write has been seen yet.
- **ACC_ARMED** means at least one write has been seen.
- **ACC_HIDDEN** is used in peripheral mode. There the register is absent from the map.

The transitions are:

- **reset to ACC_FRESH**, for every mode except peripheral.
- **reset to ACC_HIDDEN**, for peripheral mode.
- **ACC_FRESH to ACC_ARMED**, on the first decoded write.
- **ACC_ARMED stays ACC_ARMED**.
- **ACC_HIDDEN stays ACC_HIDDEN**.

Top module: `pfa_port_assign`

## Requirements
- R1: The register decodes at byte offset 0x0A. A read at that offset returns the register with bits 1 and 0 forced to zero. A read at any other offset, or with `rd_en_i` low, returns 0x00. A write at any other offset changes nothing. Reads are combinational and writes take effect at the clock edge.
- R2: While `rst_i` is high (synchronous reset), the register loads a value chosen by `mode_i`. The mode codes are 000 special single-chip, 001 special expanded narrow, 010 peripheral, 011 special expanded wide, 100 normal single-chip, 101 normal expanded narrow, 110 treated as normal single-chip, and 111 normal expanded wide. The reset values are 0x00 for 000, 010, 101 and 111, 0x2C for 001 and 011, and 0x10 for 100 and 110.
- R3: The mode is captured only during reset. Changing `mode_i` afterwards changes neither the register contents nor the write rules.
- R4: In peripheral mode, reads return 0x00, writes are ignored and the PLL test bit (bit 6) is held clear, so `pll_sel_o` stays 0.
- R5: In normal modes (codes 1xx), bit 7 (auxiliary reset enable) can never be written.
- R6: In special modes (codes 000, 001, 011), the first write after reset discards bit 7. Every later write updates bit 7.
- R7: Bit 6 (PLL test enable) accepts every write in all non-peripheral modes.
- R8: Bits 5..2 accept writes in special modes and in normal expanded modes (101, 111). In normal single-chip modes (100, 110) they ignore writes.
- R9: When bit 7 is 1, `pin_oe_o[7]` is 0 and `aux_rst_o` follows `pin7_in_i`. When bit 7 is 0, `aux_rst_o` is 0 and pin 7 follows the direction and data inputs.
- R10: When bit 5 (pipe enable) is 1, `pipe_sel_o` is 1 and pins 6 and 5 drive `pipe_src_i[1]` and `pipe_src_i[0]`. The PLL test function applies only when bit 6 is 1, bit 5 is 0 and the mode is special expanded (001, 011). In that case `pll_sel_o` is 1 and pin 6 drives `pll_test_src_i`.
- R11: Bit 4 is active low: 0 drives `eclk_src_i` on pin 4. Bit 3 set drives `lstrb_src_i` on pin 3, and bit 2 set drives `rw_src_i` on pin 2. Each alternate output forces its pin's output enable to 1.
- R12: Any pin whose alternate function is off, and pins 1 and 0 at all times, take their output enable from `dir_i` and their output data from `dout_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; mode captured while high |
| mode_i | input | 3 | Operating mode code |
| addr_i | input | ADDR_W | Bus byte address |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data (combinational) |
| dir_i | input | 8 | Port direction register (1 = output) |
| dout_i | input | 8 | Port data register |
| pin7_in_i | input | 1 | Pin 7 input level |
| eclk_src_i | input | 1 | E-clock source |
| rw_src_i | input | 1 | Read/write strobe source |
| lstrb_src_i | input | 1 | Low-byte strobe source |
| pipe_src_i | input | 2 | Pipe status source (bit 1 to pin 6, bit 0 to pin 5) |
| pll_test_src_i | input | 1 | PLL test signal source |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_do_o | output | 8 | Per-pin output data |
| aux_rst_o | output | 1 | Auxiliary active-high reset request |
| pll_sel_o | output | 1 | Pin 6 carries the PLL test signal |
| pipe_sel_o | output | 1 | Pins 6 and 5 carry pipe status |

## Verification
The bench targets the first-write discard of bit 7 in special modes. A design that lacked the arming state would set bit 7 on the first write, and one that armed too late would also drop the second write. It resets into every mode code and compares the image that is read back. A wrong table, or a design that let a later `mode_i` change leak into the rules, shows up as a wrong readback or as a bit that accepts a write it should refuse. Pin 6 is driven with pipe enable and PLL test enable set at the same time, and PLL test is also set in a normal expanded mode, so a broken priority or a missing mode qualifier is visible on `pin_do_o`. In peripheral mode a write of 0xFF is followed by a check of the pins, which exposes any write that slipped through the hidden state.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

    localparam int CFG_W    = 8;
    localparam int BIT_ARS  = 7;
    localparam int BIT_PLL  = 6;
    localparam int BIT_PIPE = 5;
    localparam int BIT_NECL = 4;
    localparam int BIT_LSTR = 3;
    localparam int BIT_RW   = 2;

    localparam logic [2:0] MODE_PERIPH = 3'b010;

    typedef enum logic [1:0] {
        ACC_FRESH  = 2'd0,
        ACC_ARMED  = 2'd1,
        ACC_HIDDEN = 2'd2
    } acc_state_e;

    function automatic logic mode_is_periph(input logic [2:0] m);
        return m == MODE_PERIPH;
    endfunction

    function automatic logic mode_is_special(input logic [2:0] m);
        return !m[2] && (m != MODE_PERIPH);
    endfunction

    function automatic logic mode_is_expanded(input logic [2:0] m);
        return m[0];
    endfunction

    function automatic logic [CFG_W-1:0] reset_image(input logic [2:0] m);
        logic [CFG_W-1:0] img;
        img = '0;
        if (mode_is_special(m) && mode_is_expanded(m)) begin
            img[BIT_PIPE] = 1'b1;
            img[BIT_LSTR] = 1'b1;
            img[BIT_RW]   = 1'b1;
        end else if (m[2] && !mode_is_expanded(m)) begin
            img[BIT_NECL] = 1'b1;
        end
        return img;
    endfunction

endpackage

// File: rtl/pfa_bus_if.sv
module pfa_bus_if #(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 10,
    parameter int CFG_W      = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              hidden_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic              wr_sel_o,
    output logic [CFG_W-1:0]  rdata_o
);

    localparam logic [ADDR_W-1:0] OFFS      = ADDR_W'(REG_OFFSET);
    localparam int                ZERO_BITS = 2;

    logic hit;

    always_comb begin
        hit      = (addr_i == OFFS) && !hidden_i;
        wr_sel_o = wr_en_i && hit;
        rdata_o  = '0;
        if (rd_en_i && hit) begin
            rdata_o = {cfg_i[CFG_W-1:ZERO_BITS], {ZERO_BITS{1'b0}}};
        end
    end

endmodule

// File: rtl/pfa_cfg_fsm.sv
module pfa_cfg_fsm
    import pfa_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [2:0]       mode_raw_i,
    input  logic [2:0]       mode_q_i,
    input  logic             wr_sel_i,
    input  logic [CFG_W-1:0] wdata_i,
    output acc_state_e       state_o,
    output logic [CFG_W-1:0] cfg_o
);

    acc_state_e       state_q, state_d;
    logic [CFG_W-1:0] cfg_q;
    logic             special, expanded, ars_ok, alt_ok;

    always_comb begin
        special  = mode_is_special(mode_q_i);
        expanded = mode_is_expanded(mode_q_i);
        ars_ok   = special && (state_q == ACC_ARMED);
        alt_ok   = special || (mode_q_i[2] && expanded);
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= mode_is_periph(mode_raw_i) ? ACC_HIDDEN : ACC_FRESH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_FRESH:  if (wr_sel_i) state_d = ACC_ARMED;
            ACC_ARMED:  state_d = ACC_ARMED;
            ACC_HIDDEN: state_d = ACC_HIDDEN;
            default:    state_d = ACC_FRESH;
        endcase
    end

    // register contents (outputs)
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= reset_image(mode_raw_i);
        end else begin
            unique case (state_q)
                ACC_HIDDEN: cfg_q[BIT_PLL] <= 1'b0;
                ACC_FRESH, ACC_ARMED: begin
                    if (wr_sel_i) begin
                        cfg_q[BIT_PLL] <= wdata_i[BIT_PLL];
                        if (alt_ok) begin
                            cfg_q[BIT_PIPE:BIT_RW] <= wdata_i[BIT_PIPE:BIT_RW];
                        end
                        if (ars_ok) begin
                            cfg_q[BIT_ARS] <= wdata_i[BIT_ARS];
                        end
                    end
                end
                default: cfg_q <= cfg_q;
            endcase
        end
    end

    assign state_o = state_q;
    assign cfg_o   = cfg_q;

endmodule

// File: rtl/pfa_pin_mux.sv
module pfa_pin_mux
    import pfa_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             spec_exp_i,
    input  logic [PINS-1:0]  dir_i,
    input  logic [PINS-1:0]  dout_i,
    input  logic             pin7_in_i,
    input  logic             eclk_src_i,
    input  logic             rw_src_i,
    input  logic             lstrb_src_i,
    input  logic [1:0]       pipe_src_i,
    input  logic             pll_test_src_i,
    output logic [PINS-1:0]  pin_oe_o,
    output logic [PINS-1:0]  pin_do_o,
    output logic             aux_rst_o,
    output logic             pll_sel_o,
    output logic             pipe_sel_o
);

    logic [PINS-1:0] alt_en, alt_oe, alt_do;
    logic            pipe_on, pll_on;

    always_comb begin
        pipe_on = cfg_i[BIT_PIPE];
        pll_on  = cfg_i[BIT_PLL] && spec_exp_i && !pipe_on;
        alt_en  = '0;
        alt_oe  = '0;
        alt_do  = '0;
        // pin 7: auxiliary reset input
        alt_en[7] = cfg_i[BIT_ARS];
        // pin 6: pipe status beats PLL test
        alt_en[6] = pipe_on || pll_on;
        alt_oe[6] = 1'b1;
        alt_do[6] = pipe_on ? pipe_src_i[1] : pll_test_src_i;
        // pin 5: pipe status
        alt_en[5] = pipe_on;
        alt_oe[5] = 1'b1;
        alt_do[5] = pipe_src_i[0];
        // pin 4: E-clock, active-low enable
        alt_en[4] = !cfg_i[BIT_NECL];
        alt_oe[4] = 1'b1;
        alt_do[4] = eclk_src_i;
        // pin 3: low-byte strobe
        alt_en[3] = cfg_i[BIT_LSTR];
        alt_oe[3] = 1'b1;
        alt_do[3] = lstrb_src_i;
        // pin 2: read/write strobe
        alt_en[2] = cfg_i[BIT_RW];
        alt_oe[2] = 1'b1;
        alt_do[2] = rw_src_i;
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign pin_oe_o[i] = alt_en[i] ? alt_oe[i] : dir_i[i];
        assign pin_do_o[i] = alt_en[i] ? alt_do[i] : dout_i[i];
    end

    assign aux_rst_o  = cfg_i[BIT_ARS] && pin7_in_i;
    assign pll_sel_o  = pll_on;
    assign pipe_sel_o = pipe_on;

endmodule

// File: rtl/pfa_port_assign.sv
module pfa_port_assign
    import pfa_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic [7:0]        dir_i,
    input  logic [7:0]        dout_i,
    input  logic              pin7_in_i,
    input  logic              eclk_src_i,
    input  logic              rw_src_i,
    input  logic              lstrb_src_i,
    input  logic [1:0]        pipe_src_i,
    input  logic              pll_test_src_i,
    output logic [7:0]        pin_oe_o,
    output logic [7:0]        pin_do_o,
    output logic              aux_rst_o,
    output logic              pll_sel_o,
    output logic              pipe_sel_o
);

    localparam int PINS = CFG_W;

    logic [2:0]       mode_q;
    logic [CFG_W-1:0] cfg_q;
    acc_state_e       acc_state;
    logic             wr_sel, spec_exp;

    always_ff @(posedge clk_i) begin
        if (rst_i) mode_q <= mode_i;
    end

    assign spec_exp = mode_is_special(mode_q) && mode_is_expanded(mode_q);

    pfa_bus_if #(
        .ADDR_W    (ADDR_W),
        .REG_OFFSET(REG_OFFSET),
        .CFG_W     (CFG_W)
    ) bus_i (
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .hidden_i(acc_state == ACC_HIDDEN),
        .cfg_i   (cfg_q),
        .wr_sel_o(wr_sel),
        .rdata_o (rdata_o)
    );

    pfa_cfg_fsm fsm_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mode_raw_i(mode_i),
        .mode_q_i  (mode_q),
        .wr_sel_i  (wr_sel),
        .wdata_i   (wdata_i),
        .state_o   (acc_state),
        .cfg_o     (cfg_q)
    );

    pfa_pin_mux #(.PINS(PINS)) mux_i (
        .cfg_i         (cfg_q),
        .spec_exp_i    (spec_exp),
        .dir_i         (dir_i),
        .dout_i        (dout_i),
        .pin7_in_i     (pin7_in_i),
        .eclk_src_i    (eclk_src_i),
        .rw_src_i      (rw_src_i),
        .lstrb_src_i   (lstrb_src_i),
        .pipe_src_i    (pipe_src_i),
        .pll_test_src_i(pll_test_src_i),
        .pin_oe_o      (pin_oe_o),
        .pin_do_o      (pin_do_o),
        .aux_rst_o     (aux_rst_o),
        .pll_sel_o     (pll_sel_o),
        .pipe_sel_o    (pipe_sel_o)
    );

endmodule

// File: rtl/pfa_port_assign_chk.sv
module pfa_port_assign_chk
    import pfa_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 10
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic              wd7_i,
    input logic [7:0]        rdata_o,
    input logic [1:0]        dir_lo_i,
    input logic [1:0]        dout_lo_i,
    input logic              pin7_in_i,
    input logic              pipe_hi_i,
    input logic [7:0]        pin_oe_o,
    input logic [7:0]        pin_do_o,
    input logic              aux_rst_o,
    input logic              pll_sel_o,
    input logic              pipe_sel_o,
    input acc_state_e        acc_state,
    input logic [7:0]        cfg_q,
    input logic [2:0]        mode_q
);

    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

    // R1
    low_bits_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rdata_o[1:0] == 2'b00);

    // R3
    mode_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> $stable(mode_q));

    // R4
    hidden_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_state == ACC_HIDDEN) |-> (rdata_o == 8'h00 && !pll_sel_o));

    // R5
    ars_locked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_q[2] |=> $stable(cfg_q[7]));

    // R6
    first_write_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_state == ACC_FRESH && wr_en_i && addr_i == OFFS && wd7_i) |=> !cfg_q[7]);

    // R9
    aux_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        aux_rst_o |-> (!pin_oe_o[7] && pin7_in_i));

    // R10
    pipe_priority_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pipe_sel_o |-> (pin_oe_o[6] && pin_do_o[6] == pipe_hi_i && !pll_sel_o));

    // R12
    plain_pins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pin_oe_o[1:0] == dir_lo_i) && (pin_do_o[1:0] == dout_lo_i));

endmodule

bind pfa_port_assign pfa_port_assign_chk #(
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wd7_i     (wdata_i[7]),
    .rdata_o   (rdata_o),
    .dir_lo_i  (dir_i[1:0]),
    .dout_lo_i (dout_i[1:0]),
    .pin7_in_i (pin7_in_i),
    .pipe_hi_i (pipe_src_i[1]),
    .pin_oe_o  (pin_oe_o),
    .pin_do_o  (pin_do_o),
    .aux_rst_o (aux_rst_o),
    .pll_sel_o (pll_sel_o),
    .pipe_sel_o(pipe_sel_o),
    .acc_state (acc_state),
    .cfg_q     (cfg_q),
    .mode_q    (mode_q)
);

// File: tb/pfa_port_assign_tb.sv
`timescale 1ns/1ps
module pfa_port_assign_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode = 3'b000;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] dir = 8'h00, dout = 8'h00;
    logic       pin7_in = 1'b0, eclk_src = 1'b0, rw_src = 1'b0, lstrb_src = 1'b0;
    logic [1:0] pipe_src = 2'b00;
    logic       pll_src = 1'b0;
    logic [7:0] pin_oe, pin_do;
    logic       aux_rst, pll_sel, pipe_sel;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfa_port_assign dut_i (
        .clk_i(clk), .rst_i(rst), .mode_i(mode), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata),
        .dir_i(dir), .dout_i(dout), .pin7_in_i(pin7_in), .eclk_src_i(eclk_src),
        .rw_src_i(rw_src), .lstrb_src_i(lstrb_src), .pipe_src_i(pipe_src),
        .pll_test_src_i(pll_src), .pin_oe_o(pin_oe), .pin_do_o(pin_do),
        .aux_rst_o(aux_rst), .pll_sel_o(pll_sel), .pipe_sel_o(pipe_sel)
    );

    function automatic logic [7:0] exp_image(input logic [2:0] m);
        case (m)
            3'b001, 3'b011: return 8'h2C;
            3'b100, 3'b110: return 8'h10;
            default:        return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        mode = m;
        rst  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset_images();
        logic [7:0] v;
        for (int m = 0; m < 8; m++) begin
            do_reset(3'(m));
            bus_rd(8'h0A, v);
            chk($sformatf("R2 reset image mode %0d", m), v, exp_image(3'(m)));
        end
    endtask

    task automatic t_decode();
        logic [7:0] v;
        do_reset(3'b011);
        bus_rd(8'h0B, v);
        chk("R1 other offset reads zero", v, 8'h00);
        bus_wr(8'h0B, 8'hFF);
        bus_rd(8'h0A, v);
        chk("R1 stray write ignored", v, 8'h2C);
        @(negedge clk);
        addr = 8'h0A; rd_en = 1'b0;
        #1 chk("R1 no read strobe gives zero", rdata, 8'h00);
    endtask

    task automatic t_mode_latch();
        logic [7:0] v;
        do_reset(3'b100);
        mode = 3'b011;
        bus_wr(8'h0A, 8'h7C);
        bus_rd(8'h0A, v);
        chk("R3 rules fixed at reset", v, 8'h50);
        mode = 3'b000;
    endtask

    task automatic t_periph();
        logic [7:0] v;
        do_reset(3'b010);
        dir = 8'hFF; dout = 8'h00; eclk_src = 1'b0; pll_src = 1'b1;
        bus_wr(8'h0A, 8'hFF);
        bus_rd(8'h0A, v);
        chk("R4 hidden read", v, 8'h00);
        settle();
        chk("R4 pll clear", {7'd0, pll_sel}, 8'h00);
        chk("R4 write ignored, pins oe", pin_oe, 8'hFF);
        chk("R4 write ignored, pins do", pin_do, 8'h00);
        pll_src = 1'b0;
    endtask

    task automatic t_normal_writes();
        logic [7:0] v;
        do_reset(3'b101);
        bus_wr(8'h0A, 8'h80);
        bus_wr(8'h0A, 8'h80);
        bus_rd(8'h0A, v);
        chk("R5 bit7 locked in normal mode", v, 8'h00);
        bus_wr(8'h0A, 8'hEC);
        bus_rd(8'h0A, v);
        chk("R7 R8 normal expanded writes", v, 8'h6C);
        do_reset(3'b100);
        bus_wr(8'h0A, 8'h7C);
        bus_rd(8'h0A, v);
        chk("R8 normal single-chip alt bits ignored, R7 bit6 taken", v, 8'h50);
        bus_wr(8'h0A, 8'h10);
        bus_rd(8'h0A, v);
        chk("R7 bit6 cleared again", v, 8'h10);
    endtask

    task automatic t_special_ars();
        logic [7:0] v;
        do_reset(3'b011);
        bus_wr(8'h0A, 8'h80);
        bus_rd(8'h0A, v);
        chk("R6 first write drops bit7", v, 8'h00);
        bus_wr(8'h0A, 8'h80);
        bus_rd(8'h0A, v);
        chk("R6 second write sets bit7", v, 8'h80);
        dir = 8'hFF; dout = 8'hFF; pin7_in = 1'b1;
        settle();
        chk("R9 aux reset follows pin", {7'd0, aux_rst}, 8'h01);
        chk("R9 pin7 not driven", {7'd0, pin_oe[7]}, 8'h00);
        pin7_in = 1'b0;
        settle();
        chk("R9 aux reset low", {7'd0, aux_rst}, 8'h00);
        bus_wr(8'h0A, 8'h00);
        pin7_in = 1'b1;
        settle();
        chk("R9 disabled aux reset", {7'd0, aux_rst}, 8'h00);
        chk("R9 pin7 back to GPIO", {7'd0, pin_oe[7]}, 8'h01);
        pin7_in = 1'b0;
    endtask

    task automatic t_pin_mux();
        do_reset(3'b011);
        dir = 8'h00; dout = 8'h00;
        pipe_src = 2'b10; eclk_src = 1'b1; lstrb_src = 1'b1; rw_src = 1'b0; pll_src = 1'b0;
        settle();
        chk("R11 R10 alt oe at reset", pin_oe, 8'h7C);
        chk("R11 R10 alt do at reset", pin_do, 8'h58);
        pll_src = 1'b1;
        bus_wr(8'h0A, 8'h40);
        settle();
        chk("R10 pll selected", {6'd0, pll_sel, pipe_sel}, 8'h02);
        chk("R10 R11 pll oe", pin_oe, 8'h50);
        chk("R10 R11 pll do", pin_do, 8'h50);
        pipe_src = 2'b01;
        bus_wr(8'h0A, 8'h60);
        settle();
        chk("R10 pipe wins over pll", {6'd0, pll_sel, pipe_sel}, 8'h01);
        chk("R10 pipe do", pin_do, 8'h30);
        chk("R10 pipe oe", pin_oe, 8'h70);
        do_reset(3'b101);
        dir = 8'hFF; dout = 8'h00;
        bus_wr(8'h0A, 8'h50);
        settle();
        chk("R10 pll inert in normal expanded", {7'd0, pll_sel}, 8'h00);
        chk("R10 pin6 follows port regs", pin_do, 8'h00);
        chk("R12 oe from dir", pin_oe, 8'hFF);
    endtask

    task automatic t_gpio();
        do_reset(3'b100);
        dir = 8'hA5; dout = 8'h3C;
        settle();
        chk("R12 GPIO oe", pin_oe, 8'hA5);
        chk("R12 GPIO do", pin_do, 8'h3C);
        dir = 8'h5A; dout = 8'hC3;
        settle();
        chk("R12 GPIO oe inverted", pin_oe, 8'h5A);
        chk("R12 GPIO do inverted", pin_do, 8'hC3);
    endtask

    initial begin
        t_reset_images();
        t_decode();
        t_mode_latch();
        t_periph();
        t_normal_writes();
        t_special_ars();
        t_pin_mux();
        t_gpio();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule